// File: doc/BRIEF.md
# Alternate Memory Master Bus Handover

This block sits on the memory-controller side of an SDRAM bank whose pins can be shared with an external bus master. When the external master raises its request, the block first holds off new memory operations and refreshes, then waits until any in-flight access and any outstanding refresh cycle have finished. After that it runs a fixed, memory-clock-paced handover. The shared bank's clock-enable drops. The block's drivers on the shared pins turn off. The grant rises. Clock-enable is then restored, now under the external master's clocking.

When the request falls, the block runs a mirror-image release. Clock-enable drops, the grant falls, the block's drivers come back on, and clock-enable is restored. Only then are ordinary memory operations and refreshes allowed again. The block counts in memory-clock periods, and each period is `MCLK_DIV` core-clock cycles (default 2). Every output change lands on a memory-clock boundary. All pins are plain level control signals, with no data path and no back-pressure.

Top module: `abh_handover`

## Requirements
- R1: After reset the block is idle: `bus_gnt`=0, `cke_shared`=1, `pins_drive`=1 and `op_hold`=0.
- R2: After a request is accepted, `op_hold` is 1. `cke_shared` stays 1 while `mem_busy` or `rfsh_busy` is 1, and it falls only at a memory-clock boundary where both were 0.
- R3: Let t be the memory clock in which `cke_shared` falls to start a handover. `pins_drive` falls at t+1, `bus_gnt` rises at t+2, and `cke_shared` rises at t+4. One memory clock is `MCLK_DIV` core cycles.
- R4: While the request stays 1 after the handover completes, `bus_gnt` stays 1, so request and grant are both high throughout the granted period.
- R5: `op_hold` stays 1 from acceptance of the request until the release completes, so that no refresh or memory operation is issued while the shared pins are released.
- R6: Let r be the first memory-clock boundary in the fully granted state at which the request is 0. `cke_shared` falls at r, `bus_gnt` falls at r+1, `pins_drive` rises at r+2, and `cke_shared` rises at r+3 together with `op_hold` falling.
- R7: A request that falls before the grant is given has no effect on the handover. The grant still rises, and the normal release follows.
- R8: Outputs change only in the core cycle that follows a memory-clock boundary. Boundaries occur every `MCLK_DIV` core cycles, counted from reset.
- R9: `pins_drive` is 0 whenever `bus_gnt` is 1, so the block and the external master never both drive the shared pins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | External master requests the shared bank's bus (active high) |
| mem_busy | input | 1 | A memory operation is pending or in progress |
| rfsh_busy | input | 1 | A refresh cycle is outstanding |
| bus_gnt | output | 1 | Bus granted to the external master (active high) |
| cke_shared | output | 1 | SDRAM clock-enable of the shared bank |
| pins_drive | output | 1 | 1: the block drives the shared bank's pins; 0: tristated |
| op_hold | output | 1 | Holds off new memory operations and refreshes |

## Verification
The handover is exercised with a request that arrives while both busy inputs are low, which shows the minimum latency. It is also exercised with a request held off by long `mem_busy` or `rfsh_busy` stretches, which shows that the busy inputs gate the start and gate nothing else. A short request pulse that falls before the grant separates a block that completes the sequence from one that aborts it. Long and back-to-back grants separate the release path from a re-entry into the handover. Random toggling of all three inputs lands requests and busy edges at every offset within a memory clock. This tests the alignment of each step and whether a step is ever skipped or repeated.

// File: rtl/abh_pkg.sv
package abh_pkg;

  // Handover sequencer steps; names give position relative to t (grant) or r (release)
  typedef enum logic [3:0] {
    ST_IDLE     = 4'd0,
    ST_DRAIN    = 4'd1,
    ST_T0_CKE   = 4'd2,
    ST_T1_TRI   = 4'd3,
    ST_T2_GNT   = 4'd4,
    ST_T3_EXT   = 4'd5,
    ST_GRANTED  = 4'd6,
    ST_R0_CKE   = 4'd7,
    ST_R1_UNGNT = 4'd8,
    ST_R2_DRV   = 4'd9
  } abh_state_e;

  typedef struct packed {
    logic gnt;
    logic cke;
    logic drive;
    logic hold;
  } abh_ctl_t;

endpackage

// File: rtl/abh_tick_gen.sv
module abh_tick_gen #(
  parameter int unsigned MCLK_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int unsigned CW = (MCLK_DIV > 1) ? $clog2(MCLK_DIV) : 1;

  generate
    if (MCLK_DIV > 1) begin : g_div
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk) begin
        if (!rst_n)                          cnt_q <= '0;
        else if (cnt_q == CW'(MCLK_DIV - 1)) cnt_q <= '0;
        else                                 cnt_q <= cnt_q + 1'b1;
      end

      assign tick_o = (cnt_q == CW'(MCLK_DIV - 1));

      AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o) else $error("tick repeated");  // R8
    end else begin : g_nodiv
      assign tick_o = 1'b1;
    end
  endgenerate

endmodule

// File: rtl/abh_seq.sv
module abh_seq
  import abh_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       req_i,
  input  logic       mem_busy_i,
  input  logic       rfsh_busy_i,
  output abh_state_e state_o
);
  abh_state_e st_q, st_d;
  logic       quiet;

  assign quiet = !mem_busy_i && !rfsh_busy_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:     if (req_i) st_d = ST_DRAIN;
      ST_DRAIN:    if (quiet) st_d = ST_T0_CKE;
      ST_T0_CKE:   st_d = ST_T1_TRI;
      ST_T1_TRI:   st_d = ST_T2_GNT;
      ST_T2_GNT:   st_d = ST_T3_EXT;
      ST_T3_EXT:   st_d = ST_GRANTED;
      ST_GRANTED:  if (!req_i) st_d = ST_R0_CKE;
      ST_R0_CKE:   st_d = ST_R1_UNGNT;
      ST_R1_UNGNT: st_d = ST_R2_DRV;
      ST_R2_DRV:   st_d = ST_IDLE;
      default:     st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      st_q <= ST_IDLE;
    else if (tick_i) st_q <= st_d;
  end

  assign state_o = st_q;

  AST_STEP_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != $past(st_q)) |-> $past(tick_i)) else $error("off-boundary step");  // R8

  AST_START_WHEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_T0_CKE && $past(st_q) == ST_DRAIN) |-> $past(quiet)) else $error("started while busy");  // R2

  AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) == ST_GRANTED && $past(req_i)) |-> (st_q == ST_GRANTED)) else $error("grant left early");  // R4

endmodule

// File: rtl/abh_out_dec.sv
module abh_out_dec
  import abh_pkg::*;
(
  input  abh_state_e state_i,
  output abh_ctl_t   ctl_o
);
  always_comb begin
    ctl_o = '{gnt: 1'b0, cke: 1'b1, drive: 1'b1, hold: 1'b1};
    unique case (state_i)
      ST_IDLE:     ctl_o.hold = 1'b0;
      ST_DRAIN:    ;
      ST_T0_CKE:   ctl_o.cke = 1'b0;
      ST_T1_TRI:   begin ctl_o.cke = 1'b0; ctl_o.drive = 1'b0; end
      ST_T2_GNT,
      ST_T3_EXT,
      ST_R0_CKE:   begin ctl_o.cke = 1'b0; ctl_o.drive = 1'b0; ctl_o.gnt = 1'b1; end
      ST_GRANTED:  begin ctl_o.drive = 1'b0; ctl_o.gnt = 1'b1; end
      ST_R1_UNGNT: begin ctl_o.cke = 1'b0; ctl_o.drive = 1'b0; end
      ST_R2_DRV:   ctl_o.cke = 1'b0;
      default:     ctl_o.hold = 1'b0;
    endcase
  end
endmodule

// File: rtl/abh_handover.sv
module abh_handover
  import abh_pkg::*;
#(
  parameter int unsigned MCLK_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_req,
  input  logic mem_busy,
  input  logic rfsh_busy,
  output logic bus_gnt,
  output logic cke_shared,
  output logic pins_drive,
  output logic op_hold
);
  logic       tick;
  abh_state_e state;
  abh_ctl_t   ctl;

  abh_tick_gen #(.MCLK_DIV(MCLK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_o(tick)
  );

  abh_seq u_seq (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .req_i(bus_req),
    .mem_busy_i(mem_busy), .rfsh_busy_i(rfsh_busy), .state_o(state)
  );

  abh_out_dec u_dec (.state_i(state), .ctl_o(ctl));

  assign bus_gnt    = ctl.gnt;
  assign cke_shared = ctl.cke;
  assign pins_drive = ctl.drive;
  assign op_hold    = ctl.hold;

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    bus_gnt |-> !pins_drive) else $error("drive while granted");  // R9

  AST_HOLD_WHILE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !pins_drive |-> op_hold) else $error("hold low while released");  // R5

  AST_CKE_OFF_AT_TRISTATE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pins_drive) |-> !cke_shared) else $error("tristate with cke high");  // R3

  AST_UNGRANT_BEFORE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pins_drive) |-> ($past(!bus_gnt) && !cke_shared)) else $error("bad release order");  // R6

endmodule

// File: tb/abh_handover_tb_top.sv
module abh_handover_tb_top;
  localparam int DIV = 2;
  localparam int WD_CYCLES = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_req = 1'b0, mem_busy = 1'b0, rfsh_busy = 1'b0;
  logic bus_gnt, cke_shared, pins_drive, op_hold;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  abh_handover #(.MCLK_DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .mem_busy(mem_busy),
    .rfsh_busy(rfsh_busy), .bus_gnt(bus_gnt), .cke_shared(cke_shared),
    .pins_drive(pins_drive), .op_hold(op_hold)
  );

  // Reference phase: 0 idle, 1 drain, 2..6 = t..t+4, 7..9 = r..r+2
  int ph = 0;
  int mc = 0;

  function automatic logic [3:0] exp_out(int p);  // {gnt,cke,drive,hold}
    case (p)
      0: return 4'b0110;
      1: return 4'b0111;
      2: return 4'b0011;
      3: return 4'b0001;
      4, 5, 7: return 4'b1001;
      6: return 4'b1101;
      8: return 4'b0001;
      9: return 4'b0011;
      default: return 4'b0110;
    endcase
  endfunction

  function automatic string tag_of(int p);
    if (p == 1) return "R2";
    if (p >= 2 && p <= 5) return "R3";
    if (p == 6) return "R4";
    if (p >= 7) return "R6";
    return "R1";
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ph <= 0; mc <= 0;
    end else begin
      mc <= (mc + 1) % DIV;
      if (mc == DIV - 1) begin
        case (ph)
          0: if (bus_req) ph <= 1;
          1: if (!mem_busy && !rfsh_busy) ph <= 2;
          6: if (!bus_req) ph <= 7;
          9: ph <= 0;
          default: ph <= ph + 1;
        endcase
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", tag, what, act, expv, cyc);
    end
  endtask

  // Edge-timing monitor
  logic [3:0] prev;
  int t0 = -1, r0 = -1;
  bit seen_gnt = 1'b0;

  always @(negedge clk) begin
    logic [3:0] now, e;
    cyc++;
    now = {bus_gnt, cke_shared, pins_drive, op_hold};
    if (rst_n) begin
      e = exp_out(ph);
      chk(now == e, tag_of(ph), "outputs {gnt,cke,drv,hold}", int'(now), int'(e));
      chk(op_hold == (ph != 0), "R5", "op_hold", int'(op_hold), int'(ph != 0));
      chk(!(bus_gnt && pins_drive), "R9", "drive while granted", int'(pins_drive), 0);
      if (now != prev) chk(mc == 0, "R8", "change off boundary, phase", mc, 0);
      if (bus_gnt) seen_gnt = 1'b1;
      if (prev[2] && !cke_shared && !bus_gnt) t0 = cyc;
      if (prev[2] && !cke_shared && bus_gnt) r0 = cyc;
      if (prev[1] && !pins_drive && t0 >= 0) chk(cyc - t0 == DIV, "R3", "tristate delay", cyc - t0, DIV);
      if (!prev[3] && bus_gnt && t0 >= 0) chk(cyc - t0 == 2*DIV, "R3", "grant delay", cyc - t0, 2*DIV);
      if (!prev[2] && cke_shared && bus_gnt && t0 >= 0) begin
        chk(cyc - t0 == 4*DIV, "R3", "cke restore delay", cyc - t0, 4*DIV); t0 = -1;
      end
      if (prev[3] && !bus_gnt && r0 >= 0) chk(cyc - r0 == DIV, "R6", "ungrant delay", cyc - r0, DIV);
      if (!prev[1] && pins_drive && r0 >= 0) chk(cyc - r0 == 2*DIV, "R6", "redrive delay", cyc - r0, 2*DIV);
      if (!prev[2] && cke_shared && !bus_gnt && r0 >= 0) begin
        chk(cyc - r0 == 3*DIV, "R6", "release cke delay", cyc - r0, 3*DIV); r0 = -1;
      end
    end
    prev = now;
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (op_hold && guard < 2000) begin @(negedge clk); guard++; end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(WD_CYCLES * 8);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    wait_cyc(4);
    // R1: reset state
    chk({bus_gnt, cke_shared, pins_drive, op_hold} == 4'b0110, "R1", "reset outputs",
        int'({bus_gnt, cke_shared, pins_drive, op_hold}), 6);
    rst_n = 1'b1;
    wait_cyc(3);
    chk({bus_gnt, cke_shared, pins_drive, op_hold} == 4'b0110, "R1", "idle outputs",
        int'({bus_gnt, cke_shared, pins_drive, op_hold}), 6);

    // Minimum-latency handover and release
    bus_req = 1'b1; wait_cyc(30);
    chk(bus_gnt == 1'b1, "R4", "grant while requested", int'(bus_gnt), 1);
    bus_req = 1'b0; wait_idle();

    // R2: handover blocked by busy memory access, then by refresh
    mem_busy = 1'b1; bus_req = 1'b1; wait_cyc(20);
    chk(cke_shared == 1'b1 && op_hold == 1'b1, "R2", "cke held while mem busy",
        int'(cke_shared), 1);
    mem_busy = 1'b0; rfsh_busy = 1'b1; wait_cyc(15);
    chk(cke_shared == 1'b1, "R2", "cke held while refresh busy", int'(cke_shared), 1);
    rfsh_busy = 1'b0; wait_cyc(20);
    chk(bus_gnt == 1'b1, "R2", "grant after drain", int'(bus_gnt), 1);
    bus_req = 1'b0; wait_idle();

    // R7: short request pulse dropped before grant
    seen_gnt = 1'b0;
    bus_req = 1'b1; wait_cyc(2); bus_req = 1'b0;
    wait_cyc(3); wait_idle();
    chk(seen_gnt == 1'b1, "R7", "grant after short pulse", int'(seen_gnt), 1);
    chk(op_hold == 1'b0 && bus_gnt == 1'b0, "R7", "back to idle", int'(op_hold), 0);

    // Back-to-back requests
    bus_req = 1'b1; wait_cyc(14); bus_req = 1'b0; wait_cyc(1); bus_req = 1'b1;
    wait_cyc(40); bus_req = 1'b0; wait_idle();

    // Random mix
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if ($urandom_range(0, 15) == 0) bus_req = ~bus_req;
      mem_busy  = ($urandom_range(0, 3) == 0);
      rfsh_busy = ($urandom_range(0, 9) == 0);
    end
    bus_req = 1'b0; mem_busy = 1'b0; rfsh_busy = 1'b0;
    wait_idle(); wait_cyc(4);
    chk({bus_gnt, cke_shared, pins_drive, op_hold} == 4'b0110, "R6", "final idle",
        int'({bus_gnt, cke_shared, pins_drive, op_hold}), 6);
    finish_run();
  end

endmodule